// File: doc/BRIEF.md
# Multiprocessor Interrupt Router

This block routes interrupts among the four cores of a small multiprocessor. Every core has a local controller with a fixed identifier. Each controller keeps a pending set of 256 vectors. It shows the highest pending vector to its core and drops that vector when the core acknowledges it.

External device lines are edge-triggered and pass through a redirection table. Each table entry gives its line a vector number, a priority class, a target core identifier and a mask. Only writes made at kernel privilege change the table. When several device events wait at once, they are handed to the cores one per cycle, with the highest priority first.

Cores can also send inter-processor messages. A message goes to one core chosen by identifier, to the sender itself, to every core, or to every core except the sender.

Top module: `irq_router`

## Requirements
- R1: After reset, every redirection entry is masked with vector, priority and target at zero, every pending set is empty, and every `irq_valid` bit is low.
- R2: A table write takes effect only when `cfg_we` and `cfg_kernel` are both high, and then only on entry `cfg_idx`. A write with `cfg_kernel` low leaves the table unchanged. The `cfg_wdata` fields are: bit 12 mask, bits 11:10 priority, bits 9:8 target core identifier, bits 7:0 vector.
- R3: A rising edge on `dev_line[i]` is seen at clock k by comparing the line with its sample from the cycle before, which resets to 0. If entry i is unmasked, its vector is pending at the target core after clock k+1, and not after clock k alone. An edge on a masked entry is dropped, and unmasking the entry later does not bring it back.
- R4: Device events that wait together are delivered one per clock. The highest priority value goes first, and among equal priorities the lower device index goes first.
- R5: Core c has identifier c. A device target or a message destination identifier selects exactly that core.
- R6: An IPI with `ipi_mode` 00 sets `ipi_vec` pending only at the core whose identifier equals `ipi_dest`. The vector is visible one clock after the clock that samples `ipi_valid`.
- R7: An IPI with `ipi_mode` 01 sets the vector pending only at the sender `ipi_src`, whatever `ipi_dest` holds.
- R8: An IPI with `ipi_mode` 10 sets the vector at every core. With `ipi_mode` 11 it sets the vector at every core except the sender.
- R9: `irq_valid[c]` is high exactly when core c has a pending vector. `irq_vec[c*8 +: 8]` then holds the largest pending vector number.
- R10: `core_ack[c]` clears the presented vector at that clock, and the next largest vector is presented after it. An ack with nothing pending has no effect. A new setting of the same vector in the same clock wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Redirection table write strobe |
| cfg_kernel | input | 1 | Writer runs at kernel privilege |
| cfg_idx | input | 3 | Entry index to write |
| cfg_wdata | input | 13 | Entry value {mask, priority, target, vector} |
| dev_line | input | 8 | Edge-triggered device interrupt lines |
| ipi_valid | input | 1 | Inter-processor message strobe |
| ipi_src | input | 2 | Identifier of the sending core |
| ipi_mode | input | 2 | Destination mode |
| ipi_dest | input | 2 | Destination identifier for mode 00 |
| ipi_vec | input | 8 | Message vector |
| core_ack | input | 4 | Per-core acknowledge of the presented vector |
| irq_valid | output | 4 | Per-core pending indication |
| irq_vec | output | 32 | Per-core presented vector, core c in bits c*8+7:c*8 |

## Verification
The message path is swept over every sender, mode and destination identifier. Each case checks all four cores, which separates the four modes and also catches any confusion between sender and destination. The device path is swept over every line and every target core, and each case also checks the cycle before arrival. This exposes routing errors and latency errors. Three lines of mixed priority are fired together, and acks are then used to read the order in which they arrive. Further sequences of ordering and acks, user-level writes, and masked edges separate the largest-vector rule, the dropped write and the dropped edge from the normal cases.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int VEC_W   = 8;
    localparam int NUM_VEC = 1 << VEC_W;
    localparam int PRIO_W  = 2;
    localparam int ID_W    = 2;
    localparam int CFG_W   = 1 + PRIO_W + ID_W + VEC_W;

    typedef enum logic [1:0] {
        DM_ONE    = 2'b00,
        DM_SELF   = 2'b01,
        DM_ALL    = 2'b10,
        DM_OTHERS = 2'b11
    } dest_mode_e;

    typedef struct packed {
        logic              masked;
        logic [PRIO_W-1:0] prio;
        logic [ID_W-1:0]   dest;
        logic [VEC_W-1:0]  vec;
    } redir_t;

    typedef struct packed {
        logic             valid;
        logic [ID_W-1:0]  dest;
        logic [VEC_W-1:0] vec;
    } deliver_t;

    function automatic logic [ID_W-1:0] core_id(input int c);
        return c[ID_W-1:0];
    endfunction

endpackage

// File: rtl/irq_redir_table.sv
module irq_redir_table
    import irq_router_pkg::*;
#(
    parameter int NUM_DEV = 8,
    localparam int IDX_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic               cfg_kernel,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  redir_t             cfg_entry,
    input  logic [NUM_DEV-1:0] dev_line,
    output deliver_t           dlv
);

    redir_t [NUM_DEV-1:0] tbl;
    logic   [NUM_DEV-1:0] line_q;
    logic   [NUM_DEV-1:0] pend;
    logic   [NUM_DEV-1:0] accept;
    logic   [NUM_DEV-1:0] grant;
    logic                 win_found;
    logic   [IDX_W-1:0]   win_idx;
    logic   [PRIO_W-1:0]  win_prio;
    logic                 wr_ok;

    assign wr_ok = cfg_we && cfg_kernel && (int'(cfg_idx) < NUM_DEV);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_DEV; i++) begin
                tbl[i] <= '{masked: 1'b1, prio: '0, dest: '0, vec: '0};
            end
        end else if (wr_ok) begin
            tbl[cfg_idx] <= cfg_entry;
        end
    end

    // Edge detection and masking at arrival
    always_comb begin
        for (int i = 0; i < NUM_DEV; i++) begin
            accept[i] = dev_line[i] && !line_q[i] && !tbl[i].masked;
        end
    end

    // Priority pick: strict compare in ascending order keeps lower index on ties
    always_comb begin
        win_found = 1'b0;
        win_idx   = '0;
        win_prio  = '0;
        for (int i = 0; i < NUM_DEV; i++) begin
            if (pend[i] && (!win_found || tbl[i].prio > win_prio)) begin
                win_found = 1'b1;
                win_idx   = IDX_W'(i);
                win_prio  = tbl[i].prio;
            end
        end
    end

    assign grant = win_found ? (NUM_DEV'(1) << win_idx) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= '0;
            pend   <= '0;
        end else begin
            line_q <= dev_line;
            pend   <= (pend & ~grant) | accept;
        end
    end

    assign dlv.valid = win_found;
    assign dlv.dest  = tbl[win_idx].dest;
    assign dlv.vec   = tbl[win_idx].vec;

    p_user_write_ignored_r2: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !cfg_kernel) |=> $stable(tbl));

    p_one_grant_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    p_grant_pending_r4: assert property (@(posedge clk) disable iff (rst)
        (grant & ~pend) == '0);

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_edge_chk
        p_edge_latched_r3: assert property (@(posedge clk) disable iff (rst)
            accept[g] |=> pend[g]);
    end

endmodule

// File: rtl/irq_ipi_decode.sv
module irq_ipi_decode
    import irq_router_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ipi_valid,
    input  logic [ID_W-1:0]      ipi_src,
    input  dest_mode_e           ipi_mode,
    input  logic [ID_W-1:0]      ipi_dest,
    output logic [NUM_CORES-1:0] hit
);

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        always_comb begin
            hit[c] = 1'b0;
            if (ipi_valid) begin
                unique case (ipi_mode)
                    DM_ONE:    hit[c] = (ipi_dest == core_id(c));
                    DM_SELF:   hit[c] = (ipi_src == core_id(c));
                    DM_ALL:    hit[c] = 1'b1;
                    DM_OTHERS: hit[c] = (ipi_src != core_id(c));
                    default:   hit[c] = 1'b0;
                endcase
            end
        end
    end

    p_self_r7: assert property (@(posedge clk) disable iff (rst)
        (ipi_valid && ipi_mode == DM_SELF && int'(ipi_src) < NUM_CORES)
            |-> ($onehot(hit) && hit[ipi_src]));

    p_others_r8: assert property (@(posedge clk) disable iff (rst)
        (ipi_valid && ipi_mode == DM_OTHERS && int'(ipi_src) < NUM_CORES)
            |-> ($countones(hit) == NUM_CORES - 1 && !hit[ipi_src]));

    p_idle_no_hit_r6: assert property (@(posedge clk) disable iff (rst)
        !ipi_valid |-> (hit == '0));

endmodule

// File: rtl/irq_core_pend.sv
module irq_core_pend
    import irq_router_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             dev_set,
    input  logic [VEC_W-1:0] dev_vec,
    input  logic             ipi_set,
    input  logic [VEC_W-1:0] ipi_vec,
    input  logic             ack,
    output logic             irq_valid,
    output logic [VEC_W-1:0] irq_vec
);

    logic [NUM_VEC-1:0] bm;
    logic [NUM_VEC-1:0] set_m;
    logic [NUM_VEC-1:0] clr_m;

    always_comb begin
        set_m = '0;
        if (dev_set) set_m[dev_vec] = 1'b1;
        if (ipi_set) set_m[ipi_vec] = 1'b1;
    end

    always_comb begin
        clr_m = '0;
        if (ack && irq_valid) clr_m[irq_vec] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) bm <= '0;
        else     bm <= (bm & ~clr_m) | set_m;
    end

    // Largest set index wins: later iterations override earlier ones
    always_comb begin
        irq_vec = '0;
        for (int i = 0; i < NUM_VEC; i++) begin
            if (bm[i]) irq_vec = VEC_W'(i);
        end
    end

    assign irq_valid = |bm;

    p_present_max_r9: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> ((bm >> irq_vec) == NUM_VEC'(1)));

    p_ack_clears_r10: assert property (@(posedge clk) disable iff (rst)
        (ack && irq_valid && !set_m[irq_vec]) |=> !bm[$past(irq_vec)]);

    p_ipi_visible_r6: assert property (@(posedge clk) disable iff (rst)
        ipi_set |=> bm[$past(ipi_vec)]);

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int NUM_DEV   = 8,
    localparam int IDX_W    = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cfg_we,
    input  logic                       cfg_kernel,
    input  logic [IDX_W-1:0]           cfg_idx,
    input  logic [CFG_W-1:0]           cfg_wdata,
    input  logic [NUM_DEV-1:0]         dev_line,
    input  logic                       ipi_valid,
    input  logic [ID_W-1:0]            ipi_src,
    input  logic [1:0]                 ipi_mode,
    input  logic [ID_W-1:0]            ipi_dest,
    input  logic [VEC_W-1:0]           ipi_vec,
    input  logic [NUM_CORES-1:0]       core_ack,
    output logic [NUM_CORES-1:0]       irq_valid,
    output logic [NUM_CORES*VEC_W-1:0] irq_vec
);

    deliver_t             dlv;
    logic [NUM_CORES-1:0] ipi_hit;
    logic [NUM_CORES-1:0] dev_hit;

    irq_redir_table #(.NUM_DEV(NUM_DEV)) u_table (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_kernel (cfg_kernel),
        .cfg_idx    (cfg_idx),
        .cfg_entry  (redir_t'(cfg_wdata)),
        .dev_line   (dev_line),
        .dlv        (dlv)
    );

    irq_ipi_decode #(.NUM_CORES(NUM_CORES)) u_ipi (
        .clk       (clk),
        .rst       (rst),
        .ipi_valid (ipi_valid),
        .ipi_src   (ipi_src),
        .ipi_mode  (dest_mode_e'(ipi_mode)),
        .ipi_dest  (ipi_dest),
        .hit       (ipi_hit)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        assign dev_hit[c] = dlv.valid && (dlv.dest == core_id(c));

        irq_core_pend u_pend (
            .clk       (clk),
            .rst       (rst),
            .dev_set   (dev_hit[c]),
            .dev_vec   (dlv.vec),
            .ipi_set   (ipi_hit[c]),
            .ipi_vec   (ipi_vec),
            .ack       (core_ack[c]),
            .irq_valid (irq_valid[c]),
            .irq_vec   (irq_vec[c*VEC_W +: VEC_W])
        );
    end

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (irq_valid == '0));

    p_single_target_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dev_hit));

endmodule

// File: tb/irq_router_tb_top.sv
module irq_router_tb_top;

    localparam int NC = 4;
    localparam int ND = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic          cfg_kernel = 1'b0;
    logic [2:0]    cfg_idx = '0;
    logic [12:0]   cfg_wdata = '0;
    logic [ND-1:0] dev_line = '0;
    logic          ipi_valid = 1'b0;
    logic [1:0]    ipi_src = '0;
    logic [1:0]    ipi_mode = '0;
    logic [1:0]    ipi_dest = '0;
    logic [7:0]    ipi_vec = '0;
    logic [NC-1:0] core_ack = '0;
    logic [NC-1:0] irq_valid;
    logic [NC*8-1:0] irq_vec;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_router #(.NUM_CORES(NC), .NUM_DEV(ND)) dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_kernel(cfg_kernel),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .dev_line(dev_line),
        .ipi_valid(ipi_valid), .ipi_src(ipi_src), .ipi_mode(ipi_mode),
        .ipi_dest(ipi_dest), .ipi_vec(ipi_vec), .core_ack(core_ack),
        .irq_valid(irq_valid), .irq_vec(irq_vec)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Check one core: presence and, when present, the vector
    task automatic chk_core(string req, int c, bit ev, int evec);
        chk(req, int'(irq_valid[c]), int'(ev));
        if (ev) chk(req, int'(irq_vec[c*8 +: 8]), evec);
    endtask

    task automatic cfg(int idx, bit kern, bit m, int pr, int dst, int v);
        cfg_we     = 1'b1;
        cfg_kernel = kern;
        cfg_idx    = 3'(idx);
        cfg_wdata  = {m, 2'(pr), 2'(dst), 8'(v)};
        tick();
        cfg_we     = 1'b0;
        cfg_kernel = 1'b0;
    endtask

    task automatic drain();
        for (int n = 0; n < 300 && irq_valid != '0; n++) begin
            core_ack = irq_valid;
            tick();
        end
        core_ack = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick();
        tick();
        rst = 1'b0;
        tick();
        // R1: idle after reset
        chk("R1 idle", int'(irq_valid), 0);
        // R1: reset table is masked, so an edge delivers nothing
        dev_line = 8'hFF;
        tick(); tick(); tick();
        chk("R1 masked default", int'(irq_valid), 0);
        dev_line = '0;
        tick();

        // R2: user-level write ignored
        cfg(0, 1'b1, 1'b0, 0, 1, 8'h40);
        cfg(0, 1'b0, 1'b0, 0, 2, 8'h50);
        dev_line[0] = 1'b1;
        tick(); tick();
        chk_core("R2 kernel cfg kept", 1, 1'b1, 8'h40);
        chk_core("R2 user write ignored", 2, 1'b0, 0);
        dev_line[0] = 1'b0;
        drain();

        // R3: masked edge dropped and not revived by unmasking
        cfg(1, 1'b1, 1'b1, 0, 0, 8'h33);
        dev_line[1] = 1'b1;
        tick(); tick(); tick();
        chk_core("R3 masked edge", 0, 1'b0, 0);
        cfg(1, 1'b1, 1'b0, 0, 0, 8'h33);
        tick(); tick();
        chk_core("R3 unmask no revive", 0, 1'b0, 0);
        dev_line[1] = 1'b0;
        tick();

        // R3/R5: sweep every line to every core, with latency
        for (int d = 0; d < ND; d++) begin
            for (int t = 0; t < NC; t++) begin
                int v;
                v = 8'h20 + d * 4 + t;
                cfg(d, 1'b1, 1'b0, d % 4, t, v);
                dev_line[d] = 1'b1;
                tick();
                chk_core("R3 latency early", t, 1'b0, 0);
                tick();
                for (int c = 0; c < NC; c++) begin
                    chk_core("R5 device route", c, c == t, v);
                end
                dev_line[d] = 1'b0;
                drain();
            end
        end

        // R6/R7/R8/R5: sweep every sender, mode and destination
        for (int s = 0; s < NC; s++) begin
            for (int m = 0; m < 4; m++) begin
                for (int dd = 0; dd < NC; dd++) begin
                    int v;
                    bit [NC-1:0] em;
                    v = 8'h80 + s * 16 + m * 4 + dd;
                    case (m)
                        0: em = NC'(1) << dd;
                        1: em = NC'(1) << s;
                        2: em = '1;
                        default: em = ~(NC'(1) << s);
                    endcase
                    ipi_valid = 1'b1;
                    ipi_src   = 2'(s);
                    ipi_mode  = 2'(m);
                    ipi_dest  = 2'(dd);
                    ipi_vec   = 8'(v);
                    tick();
                    ipi_valid = 1'b0;
                    for (int c = 0; c < NC; c++) begin
                        case (m)
                            0: chk_core("R6 ipi one", c, em[c], v);
                            1: chk_core("R7 ipi self", c, em[c], v);
                            default: chk_core("R8 ipi all/others", c, em[c], v);
                        endcase
                    end
                    drain();
                end
            end
        end

        // R9/R10: largest vector presented, acks walk downward
        ipi_mode = 2'b00; ipi_dest = 2'd0; ipi_src = 2'd2;
        ipi_valid = 1'b1; ipi_vec = 8'd3;
        tick();
        chk_core("R9 single", 0, 1'b1, 3);
        ipi_vec = 8'd200;
        tick();
        chk_core("R9 larger wins", 0, 1'b1, 200);
        ipi_vec = 8'd77;
        tick();
        ipi_valid = 1'b0;
        chk_core("R9 smaller waits", 0, 1'b1, 200);
        core_ack[0] = 1'b1;
        tick();
        chk_core("R10 ack next", 0, 1'b1, 77);
        tick();
        chk_core("R10 ack next2", 0, 1'b1, 3);
        tick();
        chk_core("R10 ack empty", 0, 1'b0, 0);
        tick();
        core_ack[0] = 1'b0;
        chk_core("R10 ack on empty ignored", 0, 1'b0, 0);
        ipi_valid = 1'b1; ipi_vec = 8'd9;
        tick();
        chk_core("R10 set", 0, 1'b1, 9);
        core_ack[0] = 1'b1;
        tick();
        ipi_valid = 1'b0;
        chk_core("R10 set beats clear", 0, 1'b1, 9);
        tick();
        core_ack[0] = 1'b0;
        chk_core("R10 cleared", 0, 1'b0, 0);

        // R4: simultaneous edges delivered by priority, ties to lower index
        cfg(2, 1'b1, 1'b0, 1, 3, 8'h10);
        cfg(5, 1'b1, 1'b0, 3, 3, 8'h08);
        cfg(6, 1'b1, 1'b0, 3, 3, 8'h05);
        dev_line = 8'b0110_0100;
        tick();
        tick();
        chk_core("R4 highest prio first", 3, 1'b1, 8'h08);
        core_ack[3] = 1'b1;
        tick();
        chk_core("R4 tie lower index", 3, 1'b1, 8'h05);
        tick();
        chk_core("R4 lowest prio last", 3, 1'b1, 8'h10);
        tick();
        core_ack[3] = 1'b0;
        chk_core("R4 all consumed", 3, 1'b0, 0);
        dev_line = '0;
        tick();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule